// File: doc/BRIEF.md
# Gain and Interpolate-by-Two FIR Stage

This block is the front stage of one up-converter channel. Each accepted complex sample (I and Q) is first scaled by the channel's own 8-bit signed gain. The scaled sample then enters a 63-tap interpolating filter that produces two output samples for every input sample. That doubles the sample rate before the later interpolation and mixing stages.

The filter is built as two polyphase branches: an even branch of 32 taps and an odd branch of 31 taps. Both branches run on one shared multiply-accumulate unit, which alternates between the I and Q rails cycle by cycle. Taps come from one of two sources, chosen by a select input: a built-in default set, or a set the user loads through a small write port. The active tap set is captured at each sample boundary, so a tap set that is only partly updated never reaches an output.

Top module: `gain_interp2_fir`

## Requirements
- R1: An accepted sample x with gain G (8-bit two's complement, -128..127) enters the filter history as floor(x*G/128), saturated to the signed 16-bit range. The gain is sampled in the same cycle as the sample, and each rail is scaled on its own.
- R2: A sample accepted with G = 0 adds nothing to the filter. After 32 consecutive zero-gain samples, both outputs of both rails are 0.
- R3: With history x[n] (newest) back to x[n-31] and taps h[0..62], the first output of a sample is the sum of h[2k]*x[n-k] for k = 0..31, and the second output is the sum of h[2k+1]*x[n-k] for k = 0..30. The first output is always delivered before the second.
- R4: If a sample is accepted at clock edge E0, out_valid is high for exactly one cycle after edge E0+65, carrying the first output, and for exactly one cycle after edge E0+129, carrying the second output. It is low at all other times.
- R5: Taps are Q1.15 signed. Each sum is kept at full precision, then becomes (sum + 2^14) >> 15 with an arithmetic shift, saturated to -32768..32767.
- R6: When coef_sel is 0 at the accepting edge, the taps are h[31] = 32767, h[30] = h[32] = 16384, and all other taps are 0.
- R7: When coef_sel is 1 at the accepting edge, the user taps are used. A write with coef_we high stores coef_wdata as tap coef_addr for addresses 0..62. A write to address 63 is ignored. After reset, all user taps are 0.
- R8: A tap write or a coef_sel change has no effect on the outputs of a sample that has already been accepted. It applies from the next accepted sample on. A write made at the very edge that accepts a sample applies from the sample after that one.
- R9: A sample is accepted only when in_valid is high and the block is idle. An accepted sample keeps the block busy for 128 edges, and in_valid during that time is ignored. Consecutive samples can therefore be accepted at most once every 129 cycles.
- R10: After reset, out_valid is 0, out_i and out_q are 0, the history is all zero, and the active taps are the default set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gain | input | 8 | Signed channel gain, value G/128 |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 16 | Signed I input sample |
| in_q | input | 16 | Signed Q input sample |
| coef_sel | input | 1 | 0 = default taps, 1 = user taps |
| coef_we | input | 1 | Tap write enable |
| coef_addr | input | 6 | Tap index to write |
| coef_wdata | input | 16 | Signed tap value |
| out_valid | output | 1 | Output sample strobe, two per input |
| out_i | output | 16 | Signed I output sample |
| out_q | output | 16 | Signed Q output sample |

## Verification
The engine goes through a fixed schedule, so both outputs of a sample are due at known edges. The first output appears one cycle after edge 65 following the accepting edge, and the second one cycle after edge 129. The bench counts edges from the accepting edge and reads out_valid, out_i and out_q just after those two edges. Ignored strobes and mid-sample tap writes are applied at the first edge after acceptance. Their lack of effect therefore shows up in the two outputs of that same sample, which the bench compares with its own model.

// File: rtl/gi2f_pkg.sv
package gi2f_pkg;
    parameter int SAMP_W = 16;
    parameter int GAIN_W = 8;
    parameter int COEF_W = 16;
    parameter int NTAPS  = 63;

    localparam int FRAC   = GAIN_W - 1;
    localparam int HIST   = (NTAPS + 1) / 2;
    localparam int KW     = $clog2(HIST);
    localparam int AW     = $clog2(NTAPS + 1);
    localparam int PROD_W = SAMP_W + COEF_W;
    localparam int ACC_W  = PROD_W + KW + 1;
    localparam int CSHIFT = COEF_W - 1;
    localparam int MID    = NTAPS / 2;

    typedef logic signed [SAMP_W-1:0] samp_t;
    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic signed [ACC_W-1:0]  acc_t;
    typedef struct packed {
        samp_t i;
        samp_t q;
    } iq_t;

    localparam samp_t SMAX = {1'b0, {(SAMP_W-1){1'b1}}};
    localparam samp_t SMIN = {1'b1, {(SAMP_W-1){1'b0}}};

    function automatic samp_t clip(input acc_t v);
        acc_t hi;
        acc_t lo;
        hi = acc_t'(SMAX);
        lo = acc_t'(SMIN);
        if (v > hi) return SMAX;
        if (v < lo) return SMIN;
        return samp_t'(v);
    endfunction

    function automatic samp_t round_clip(input acc_t a);
        acc_t r;
        r = (a + (acc_t'(1) <<< (CSHIFT - 1))) >>> CSHIFT;
        return clip(r);
    endfunction

    function automatic samp_t scale(input samp_t x, input logic signed [GAIN_W-1:0] g);
        logic signed [SAMP_W+GAIN_W-1:0] p;
        p = x * g;
        p = p >>> FRAC;
        return clip(acc_t'(p));
    endfunction

    function automatic coef_t dflt_tap(input int j);
        if (j == MID) return {1'b0, {(COEF_W-1){1'b1}}};
        if (j == MID - 1 || j == MID + 1) return coef_t'(1) <<< (COEF_W - 2);
        return '0;
    endfunction
endpackage

// File: rtl/gi2f_gain.sv
module gi2f_gain
    import gi2f_pkg::*;
(
    input  iq_t                      din,
    input  logic signed [GAIN_W-1:0] g,
    output iq_t                      dout
);
    always_comb begin
        dout.i = scale(din.i, g);
        dout.q = scale(din.q, g);
    end
endmodule

// File: rtl/gi2f_coef_bank.sv
module gi2f_coef_bank
    import gi2f_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  coef_t         wdata,
    input  logic          use_user,
    input  logic          latch,
    input  logic [AW-1:0] rd_addr,
    output coef_t         rd_coef
);
    coef_t stage [NTAPS];
    coef_t act   [NTAPS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < NTAPS; j++) begin
                stage[j] <= '0;
                act[j]   <= dflt_tap(j);
            end
        end else begin
            if (we && int'(waddr) < NTAPS) stage[waddr] <= wdata;
            if (latch) begin
                for (int j = 0; j < NTAPS; j++)
                    act[j] <= use_user ? stage[j] : dflt_tap(j);
            end
        end
    end

    assign rd_coef = (int'(rd_addr) < NTAPS) ? act[rd_addr] : '0;
endmodule

// File: rtl/gi2f_mac.sv
module gi2f_mac
    import gi2f_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  iq_t           xin,
    output logic [AW-1:0] tap,
    input  coef_t         coef,
    output logic          busy,
    output logic          ov,
    output iq_t           y
);
    samp_t hi [HIST];
    samp_t hq [HIST];
    logic [KW+1:0] cnt;
    logic          rail;
    logic          ph;
    logic [KW-1:0] k;
    logic          last;
    logic          emit;
    samp_t         xs;
    logic signed [PROD_W-1:0] prod;
    acc_t          pe;
    acc_t          acc_i;
    acc_t          acc_q;

    assign rail = cnt[0];
    assign k    = cnt[KW:1];
    assign ph   = cnt[KW+1];
    assign tap  = AW'({k, ph});
    assign last = rail && (k == KW'(HIST - 1));
    assign xs   = rail ? hq[k] : hi[k];
    assign prod = xs * coef;
    assign pe   = acc_t'(prod);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < HIST; j++) begin
                hi[j] <= '0;
                hq[j] <= '0;
            end
            cnt   <= '0;
            busy  <= 1'b0;
            emit  <= 1'b0;
            ov    <= 1'b0;
            acc_i <= '0;
            acc_q <= '0;
            y     <= '0;
        end else begin
            ov   <= 1'b0;
            emit <= 1'b0;
            if (start && !busy) begin
                hi[0] <= xin.i;
                hq[0] <= xin.q;
                for (int j = 1; j < HIST; j++) begin
                    hi[j] <= hi[j-1];
                    hq[j] <= hq[j-1];
                end
                busy <= 1'b1;
                cnt  <= '0;
            end else if (busy) begin
                if (!rail) acc_i <= (k == '0) ? pe : acc_i + pe;
                else       acc_q <= (k == '0) ? pe : acc_q + pe;
                if (last) begin
                    emit <= 1'b1;
                    if (ph) busy <= 1'b0;
                end
                cnt <= cnt + 1'b1;
            end
            if (emit) begin
                ov  <= 1'b1;
                y.i <= round_clip(acc_i);
                y.q <= round_clip(acc_q);
            end
        end
    end
endmodule

// File: rtl/gain_interp2_fir.sv
module gain_interp2_fir
    import gi2f_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic signed [GAIN_W-1:0]  gain,
    input  logic                      in_valid,
    input  logic signed [SAMP_W-1:0]  in_i,
    input  logic signed [SAMP_W-1:0]  in_q,
    input  logic                      coef_sel,
    input  logic                      coef_we,
    input  logic [AW-1:0]             coef_addr,
    input  logic signed [COEF_W-1:0]  coef_wdata,
    output logic                      out_valid,
    output logic signed [SAMP_W-1:0]  out_i,
    output logic signed [SAMP_W-1:0]  out_q
);
    logic          busy;
    logic          accept;
    iq_t           raw;
    iq_t           scaled;
    iq_t           y;
    logic [AW-1:0] tap;
    coef_t         coef;

    assign accept = in_valid && !busy;
    assign raw.i  = in_i;
    assign raw.q  = in_q;

    gi2f_gain u_gain (
        .din  (raw),
        .g    (gain),
        .dout (scaled)
    );

    gi2f_coef_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .we       (coef_we),
        .waddr    (coef_addr),
        .wdata    (coef_wdata),
        .use_user (coef_sel),
        .latch    (accept),
        .rd_addr  (tap),
        .rd_coef  (coef)
    );

    gi2f_mac u_mac (
        .clk   (clk),
        .rst   (rst),
        .start (accept),
        .xin   (scaled),
        .tap   (tap),
        .coef  (coef),
        .busy  (busy),
        .ov    (out_valid),
        .y     (y)
    );

    assign out_i = y.i;
    assign out_q = y.q;
endmodule

// File: rtl/gi2f_chk.sv
module gi2f_chk (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic out_valid,
    input logic busy
);
    // R4
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R4
    tail_output_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |=> out_valid);

    // R9
    start_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(in_valid));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !in_valid) |=> !busy);

    // R10
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && !busy));
endmodule

bind gain_interp2_fir gi2f_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .busy      (busy)
);

// File: tb/gain_interp2_fir_bench.sv
module gain_interp2_fir_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic signed [7:0]  gain = '0;
    logic in_valid = 1'b0;
    logic signed [15:0] in_i = '0;
    logic signed [15:0] in_q = '0;
    logic coef_sel = 1'b0;
    logic coef_we = 1'b0;
    logic [5:0] coef_addr = '0;
    logic signed [15:0] coef_wdata = '0;
    logic out_valid;
    logic signed [15:0] out_i;
    logic signed [15:0] out_q;

    int total = 0;
    int bad = 0;
    bit done = 0;

    longint hist_i [32];
    longint hist_q [32];
    longint stg [63];
    longint act [63];
    longint last_e_i, last_e_q, last_o_i, last_o_q;

    always #4 clk = ~clk;

    gain_interp2_fir u_gain_interp2_fir (
        .clk(clk), .rst(rst), .gain(gain), .in_valid(in_valid),
        .in_i(in_i), .in_q(in_q), .coef_sel(coef_sel), .coef_we(coef_we),
        .coef_addr(coef_addr), .coef_wdata(coef_wdata),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    function automatic longint sat(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic longint ref_gain(input longint x, input longint g);
        return sat((x * g) >>> 7);
    endfunction

    function automatic longint ref_round(input longint a);
        return sat((a + 16384) >>> 15);
    endfunction

    function automatic longint ref_dflt(input int j);
        if (j == 31) return 32767;
        if (j == 30 || j == 32) return 16384;
        return 0;
    endfunction

    task automatic chk(input string tag, input longint got, input longint exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    task automatic model_write(input int a, input longint d);
        if (a < 63) stg[a] = d;
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        coef_we = 1'b1; coef_addr = 6'(a); coef_wdata = 16'(d);
        @(negedge clk);
        coef_we = 1'b0;
        model_write(a, longint'(16'(d) ^ 16'h0) - ((d & 32'h8000) != 0 ? 65536 : 0));
    endtask

    task automatic send(input string tag, input int si, input int sq, input int g,
                        input bit junk, input bit mid_wr, input int wa, input int wd);
        longint ei, eq, oi, oq;
        logic signed [15:0] vi, vq, vd;
        logic signed [7:0] vg;
        vi = 16'(si); vq = 16'(sq); vg = 8'(g); vd = 16'(wd);
        @(negedge clk);
        in_valid = 1'b1; in_i = vi; in_q = vq; gain = vg;
        @(posedge clk);
        for (int j = 31; j > 0; j--) begin
            hist_i[j] = hist_i[j-1];
            hist_q[j] = hist_q[j-1];
        end
        hist_i[0] = ref_gain(longint'(vi), longint'(vg));
        hist_q[0] = ref_gain(longint'(vq), longint'(vg));
        for (int j = 0; j < 63; j++) act[j] = coef_sel ? stg[j] : ref_dflt(j);
        ei = 0; eq = 0; oi = 0; oq = 0;
        for (int k = 0; k < 32; k++) begin
            ei += act[2*k] * hist_i[k];
            eq += act[2*k] * hist_q[k];
            if (k < 31) begin
                oi += act[2*k+1] * hist_i[k];
                oq += act[2*k+1] * hist_q[k];
            end
        end
        @(negedge clk);
        in_valid = junk;
        in_i = 16'sh7fff; in_q = -16'sh7fff; gain = 8'sh7f;
        coef_we = mid_wr; coef_addr = 6'(wa); coef_wdata = vd;
        @(posedge clk);
        if (mid_wr) model_write(wa, longint'(vd));
        @(negedge clk);
        in_valid = 1'b0; coef_we = 1'b0;
        repeat (64) @(posedge clk);
        #1;
        chk({tag, " R4 first valid"}, longint'(out_valid), 1);
        chk({tag, " R3 even I"}, longint'(out_i), ref_round(ei));
        chk({tag, " R3 even Q"}, longint'(out_q), ref_round(eq));
        last_e_i = out_i; last_e_q = out_q;
        repeat (64) @(posedge clk);
        #1;
        chk({tag, " R4 second valid"}, longint'(out_valid), 1);
        chk({tag, " R3 odd I"}, longint'(out_i), ref_round(oi));
        chk({tag, " R3 odd Q"}, longint'(out_q), ref_round(oq));
        last_o_i = out_i; last_o_q = out_q;
        @(posedge clk);
        #1;
        chk({tag, " R4 pulse ends"}, longint'(out_valid), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int j = 0; j < 32; j++) begin hist_i[j] = 0; hist_q[j] = 0; end
        for (int j = 0; j < 63; j++) stg[j] = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R10 reset valid", longint'(out_valid), 0);
        chk("R10 reset I", longint'(out_i), 0);
        chk("R10 reset Q", longint'(out_q), 0);

        // R6 and R10: default taps straight after reset, then random traffic
        send("R6 R10 first", 16000, -12000, 127, 0, 0, 0, 0);
        for (int n = 0; n < 6; n++)
            send("R6 R1 rand", int'($urandom), int'($urandom), int'($urandom), 0, 0, 0, 0);

        // R1: saturating corner of the gain
        send("R1 gain min", -32768, 32767, -128, 0, 0, 0, 0);
        send("R1 gain neg", -1, 1, -1, 0, 0, 0, 0);

        // R7: user taps, address 63 ignored
        for (int j = 0; j < 63; j++) wr(j, int'($urandom) & 32'h3fff);
        wr(63, 32767);
        coef_sel = 1'b1;
        for (int n = 0; n < 8; n++)
            send("R7 R5 user", int'($urandom), int'($urandom), int'($urandom), 0, 0, 0, 0);

        // R8 and R9: mid-sample write and ignored strobe, then select change
        send("R8 R9 mid", 20000, -20000, 100, 1, 1, 0, -30000);
        send("R8 after", 1234, -4321, 90, 1, 1, 31, 30000);
        coef_sel = 1'b0;
        send("R8 sel back", 5000, 6000, 64, 0, 0, 0, 0);
        coef_sel = 1'b1;

        // R5: saturation with all taps at full scale
        for (int j = 0; j < 63; j++) wr(j, 32767);
        for (int n = 0; n < 4; n++) send("R5 sat hi", 32767, -32768, 127, 0, 0, 0, 0);
        chk("R5 sat I", last_e_i, 32767);
        chk("R5 sat Q", last_e_q, -32768);

        // R2: zero gain flushes the history
        for (int n = 0; n < 32; n++)
            send("R2 zero gain", int'($urandom), int'($urandom), 0, 0, 0, 0, 0);
        chk("R2 even I zero", last_e_i, 0);
        chk("R2 even Q zero", last_e_q, 0);
        chk("R2 odd I zero", last_o_i, 0);
        chk("R2 odd Q zero", last_o_q, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule